// File: doc/BRIEF.md
# Parallel ADC Host Sequencer

This block sits on the host side of an 8-bit, multi-channel converter that has a parallel read port. One line on that port does two jobs. Its falling edge starts a conversion. Its level at the moment the converter reports completion decides whether the converter stays powered or goes to sleep. The sequencer takes a request with a channel number, places the address on the converter's address pins and lets it settle. It then strobes the convert line and waits for the end-of-conversion pulse. After that it runs a chip-select/read cycle and hands back the byte it read, tagged with its channel.

A mode bit sampled with each request picks one of two modes. In normal mode the convert line returns high straight after the strobe, so the converter stays awake. In auto power-down mode the line is left low, so the converter sleeps after each conversion. The sequencer records whether the converter may be asleep. When it may be, the next request raises the convert line and waits the full wake-up time before the next falling edge. All analog timing is given in nanoseconds and turned into clock counts, rounded up, from a clock-period parameter. A missing end-of-conversion pulse is caught by a cycle timeout.

Top module: `adc_host_seq`

## Requirements
- R1: During and straight after reset, the convert line, chip select and read are all high, `busy_o` is low, and neither `smp_valid_o` nor `err_o` is asserted.
- R2: When `req_i` is seen in idle, `chan_i` is driven on `adc_addr_o` and held unchanged until the block is idle again. While the converter is awake, the convert line falls exactly 25 cycles (200 ns) after the request edge. A request made while `busy_o` is high is ignored.
- R3: The convert line stays low for at least 20 ns (3 cycles) each time it falls.
- R4: In normal mode (`auto_pd_i` = 0), the convert line is high again before end of conversion. The next request then needs no wake-up wait, so its falling edge comes 25 cycles after the request.
- R5: In auto power-down mode (`auto_pd_i` = 1), the convert line stays low through end of conversion and until the next request. That request raises the line and waits the wake-up time (25 us = 3125 cycles with the internal reference) before the next falling edge. This happens whatever the mode of that request.
- R6: After the rising edge of end of conversion, chip select falls first. Read falls at least 10 ns later and stays low for at least 30 ns (4 cycles). The data bus is captured while both are low, and then both rise together.
- R7: At least 30 ns passes between the rise of read and the next fall of the convert line. `busy_o` stays high through that gap.
- R8: Each completed read gives one result: `smp_data_o` holds the byte read and `smp_chan_o` holds the requested channel, with `smp_valid_o` high for exactly one cycle.
- R9: If no end of conversion arrives within the timeout of 128 cycles after the strobe, `err_o` pulses for one cycle and no read takes place. The block returns to idle, and the next conversion waits the full wake-up time.
- R10: After reset the converter's power state is treated as unknown, so the first conversion waits the wake-up time (3125 cycles) before its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Conversion request, taken only in idle |
| chan_i | input | 3 | Channel to convert |
| auto_pd_i | input | 1 | 1 = leave converter asleep after this conversion |
| busy_o | output | 1 | Sequence in progress |
| smp_valid_o | output | 1 | One-cycle result strobe |
| smp_data_o | output | 8 | Sample byte |
| smp_chan_o | output | 3 | Channel tag of the sample |
| err_o | output | 1 | One-cycle end-of-conversion timeout flag |
| adc_addr_o | output | 3 | Converter channel address |
| adc_convst_n_o | output | 1 | Convert start / power-down line |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_eoc_i | input | 1 | End-of-conversion pulse from converter |
| adc_db_i | input | 8 | Converter data bus |

## Verification
The delay from a request to the convert line falling is fixed: 25 cycles when the converter is awake and 3125 cycles when a wake-up is due. The bench counts falling clock edges from the edge that accepted the request and compares the count with one of these exact values. The timing of end of conversion depends on the converter, so results are not tied to a fixed cycle. Instead a scoreboard pops one expected item for each `smp_valid_o` or `err_o` pulse, sampled on the falling edge after the one-cycle strobe. A bus model measures the analog time windows and returns a poisoned byte whenever one is broken.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STROBE,
    ST_CONVERT,
    ST_RSETUP,
    ST_READ,
    ST_RECOVER
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
`timescale 1ns/1ps
module adc_eoc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CHAN_W     = 3,
  parameter int unsigned TW         = 12,
  parameter int unsigned SETTLE_C   = 25,
  parameter int unsigned WAKESET_C  = 3125,
  parameter int unsigned CONVLOW_C  = 3,
  parameter int unsigned TIMEOUT_C  = 128,
  parameter int unsigned RSETUP_C   = 2,
  parameter int unsigned RDLOW_C    = 4,
  parameter int unsigned RDGAP_C    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              auto_pd_i,
  input  logic              eoc_rise_i,
  input  logic [DATA_W-1:0] db_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_val_o,
  output logic              busy_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic [CHAN_W-1:0] smp_chan_o,
  output logic              err_o,
  output logic [CHAN_W-1:0] adc_addr_o,
  output logic              adc_convst_n_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o
);
  seq_state_e state;
  logic       asleep_q;
  logic       mode_q;

  // timer reload values for the state being entered
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state)
      ST_IDLE: if (req_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = asleep_q ? TW'(WAKESET_C - 1) : TW'(SETTLE_C - 1);
      end
      ST_WAIT: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(CONVLOW_C - 1);
      end
      ST_STROBE: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(TIMEOUT_C - 1);
      end
      ST_CONVERT: if (eoc_rise_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RSETUP_C - 1);
      end
      ST_RSETUP: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RDLOW_C - 1);
      end
      ST_READ: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RDGAP_C - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      asleep_q       <= 1'b1;
      mode_q         <= 1'b0;
      adc_addr_o     <= '0;
      adc_convst_n_o <= 1'b1;
      adc_cs_n_o     <= 1'b1;
      adc_rd_n_o     <= 1'b1;
      smp_valid_o    <= 1'b0;
      smp_data_o     <= '0;
      smp_chan_o     <= '0;
      err_o          <= 1'b0;
    end else begin
      smp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      case (state)
        ST_IDLE: if (req_i) begin
          adc_addr_o     <= chan_i;
          mode_q         <= auto_pd_i;
          adc_convst_n_o <= 1'b1;
          state          <= ST_WAIT;
        end
        ST_WAIT: if (tmr_done_i) begin
          adc_convst_n_o <= 1'b0;
          asleep_q       <= 1'b0;
          state          <= ST_STROBE;
        end
        ST_STROBE: if (tmr_done_i) begin
          if (!mode_q) adc_convst_n_o <= 1'b1;
          state <= ST_CONVERT;
        end
        ST_CONVERT: begin
          if (eoc_rise_i) begin
            asleep_q   <= mode_q;
            adc_cs_n_o <= 1'b0;
            state      <= ST_RSETUP;
          end else if (tmr_done_i) begin
            err_o    <= 1'b1;
            asleep_q <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_RSETUP: if (tmr_done_i) begin
          adc_rd_n_o <= 1'b0;
          state      <= ST_READ;
        end
        ST_READ: if (tmr_done_i) begin
          smp_data_o  <= db_i;
          smp_chan_o  <= adc_addr_o;
          smp_valid_o <= 1'b1;
          adc_rd_n_o  <= 1'b1;
          adc_cs_n_o  <= 1'b1;
          state       <= ST_RECOVER;
        end
        ST_RECOVER: if (tmr_done_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/adc_host_seq.sv
`timescale 1ns/1ps
module adc_host_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CHAN_W       = 3,
  parameter int unsigned CLK_NS       = 8,
  parameter int unsigned SETTLE_NS    = 200,
  parameter int unsigned CONV_LOW_NS  = 20,
  parameter int unsigned RD_SETUP_NS  = 10,
  parameter int unsigned RD_LOW_NS    = 30,
  parameter int unsigned RD_ACCESS_NS = 20,
  parameter int unsigned RD_GAP_NS    = 30,
  parameter int unsigned WAKE_INT_NS  = 25000,
  parameter int unsigned WAKE_EXT_NS  = 1000,
  parameter bit          EXT_REF      = 1'b0,
  parameter int unsigned EOC_TIMEOUT  = 128,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              auto_pd_i,
  output logic              busy_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic [CHAN_W-1:0] smp_chan_o,
  output logic              err_o,
  output logic [CHAN_W-1:0] adc_addr_o,
  output logic              adc_convst_n_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o,
  input  logic              adc_eoc_i,
  input  logic [DATA_W-1:0] adc_db_i
);
  localparam int unsigned SETTLE_C  = ns2cyc(SETTLE_NS, CLK_NS);
  localparam int unsigned WAKE_C    = ns2cyc(EXT_REF ? WAKE_EXT_NS : WAKE_INT_NS, CLK_NS);
  localparam int unsigned WAKESET_C = umax(WAKE_C, SETTLE_C);
  localparam int unsigned CONVLOW_C = ns2cyc(CONV_LOW_NS, CLK_NS);
  localparam int unsigned RSETUP_C  = ns2cyc(RD_SETUP_NS, CLK_NS);
  localparam int unsigned RDLOW_C   = umax(ns2cyc(RD_LOW_NS, CLK_NS), ns2cyc(RD_ACCESS_NS, CLK_NS) + 1);
  localparam int unsigned RDGAP_C   = ns2cyc(RD_GAP_NS, CLK_NS);
  localparam int unsigned TIMEOUT_C = umax(EOC_TIMEOUT, 1);
  localparam int unsigned TMAX      = umax(umax(WAKESET_C, TIMEOUT_C),
                                      umax(umax(CONVLOW_C, RSETUP_C), umax(RDLOW_C, RDGAP_C)));
  localparam int unsigned TW        = $clog2(TMAX + 1);

  logic          eoc_rise;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;

  adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (adc_eoc_i),
    .rise_o  (eoc_rise)
  );

  adc_seq_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  adc_seq_ctrl #(
    .DATA_W    (DATA_W),
    .CHAN_W    (CHAN_W),
    .TW        (TW),
    .SETTLE_C  (SETTLE_C),
    .WAKESET_C (WAKESET_C),
    .CONVLOW_C (CONVLOW_C),
    .TIMEOUT_C (TIMEOUT_C),
    .RSETUP_C  (RSETUP_C),
    .RDLOW_C   (RDLOW_C),
    .RDGAP_C   (RDGAP_C)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_i          (req_i),
    .chan_i         (chan_i),
    .auto_pd_i      (auto_pd_i),
    .eoc_rise_i     (eoc_rise),
    .db_i           (adc_db_i),
    .tmr_done_i     (tmr_done),
    .tmr_load_o     (tmr_load),
    .tmr_val_o      (tmr_val),
    .busy_o         (busy_o),
    .smp_valid_o    (smp_valid_o),
    .smp_data_o     (smp_data_o),
    .smp_chan_o     (smp_chan_o),
    .err_o          (err_o),
    .adc_addr_o     (adc_addr_o),
    .adc_convst_n_o (adc_convst_n_o),
    .adc_cs_n_o     (adc_cs_n_o),
    .adc_rd_n_o     (adc_rd_n_o)
  );
endmodule

// File: rtl/adc_host_seq_chk.sv
`timescale 1ns/1ps
module adc_host_seq_chk #(
  parameter int unsigned CHAN_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              smp_valid_o,
  input logic              err_o,
  input logic [CHAN_W-1:0] adc_addr_o,
  input logic              adc_convst_n_o,
  input logic              adc_cs_n_o,
  input logic              adc_rd_n_o
);
  // R6
  rd_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n_o |-> !adc_cs_n_o);

  // R6
  cs_before_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rd_n_o) |-> $past(!adc_cs_n_o));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid_o |=> !smp_valid_o);

  // R9
  err_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!smp_valid_o && adc_cs_n_o && adc_rd_n_o));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(adc_addr_o));

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_convst_n_o) |=> !adc_convst_n_o);

  // R7
  gap_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rd_n_o) |-> busy_o);
endmodule

bind adc_host_seq adc_host_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .busy_o         (busy_o),
  .smp_valid_o    (smp_valid_o),
  .err_o          (err_o),
  .adc_addr_o     (adc_addr_o),
  .adc_convst_n_o (adc_convst_n_o),
  .adc_cs_n_o     (adc_cs_n_o),
  .adc_rd_n_o     (adc_rd_n_o)
);

// File: tb/adc_host_seq_tb.sv
`timescale 1ns/1ps
module adc_host_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [2:0] chan = '0;
  logic       auto_pd = 1'b0;
  logic       busy, valid, err, convst_n, cs_n, rd_n;
  logic [7:0] sdata;
  logic [2:0] schan, addr;
  logic       eoc = 1'b0;
  wire  [7:0] db;

  always #4 clk = ~clk;

  adc_host_seq u_dut (
    .clk(clk), .rst(rst), .req_i(req), .chan_i(chan), .auto_pd_i(auto_pd),
    .busy_o(busy), .smp_valid_o(valid), .smp_data_o(sdata), .smp_chan_o(schan),
    .err_o(err), .adc_addr_o(addr), .adc_convst_n_o(convst_n), .adc_cs_n_o(cs_n),
    .adc_rd_n_o(rd_n), .adc_eoc_i(eoc), .adc_db_i(db)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // ---------------- converter bus model ----------------
  logic [7:0] lvl = '0;
  logic [7:0] mdl_val = '0;
  bit         mute = 1'b0;
  bit         asleep_m = 1'b0;
  bit         started = 1'b0;
  bit         bad = 1'b0;
  realtime    addr_t = 0, fall_t = 0, rd_fall_t = 0, rd_rise_t = -1000, wake_at = 25000;
  int         rd_falls = 0;

  assign db = (!cs_n && !rd_n) ? mdl_val : 8'hzz;

  always @(addr) addr_t = $realtime;

  always @(posedge convst_n) begin
    if (started) begin
      // R3 low pulse width
      chk(($realtime - fall_t) >= 19.9, "R3", "convst low ns", longint'($realtime - fall_t), 20);
      if (($realtime - fall_t) < 19.9) bad = 1'b1;
    end
    if (asleep_m) begin
      asleep_m = 1'b0;
      wake_at  = $realtime + 25000;
    end
  end

  always @(negedge convst_n) begin
    if (!rst) begin
      started = 1'b1;
      fall_t  = $realtime;
      bad     = 1'b0;
      // R2 settle, R5 wake, R7 read gap
      chk(($realtime - addr_t) >= 199.9, "R2", "addr settle ns", longint'($realtime - addr_t), 200);
      chk($realtime >= wake_at - 0.1, "R5", "wake margin ns", longint'($realtime), longint'(wake_at));
      chk(($realtime - rd_rise_t) >= 29.9, "R7", "read-to-convst ns", longint'($realtime - rd_rise_t), 30);
      if (($realtime - addr_t) < 199.9 || $realtime < wake_at - 0.1 ||
          ($realtime - rd_rise_t) < 29.9) bad = 1'b1;
      if (!mute) fork
        begin
          #400;
          eoc = 1'b1;
          asleep_m = !convst_n;
          mdl_val  = bad ? 8'hEE : lvl;
          #100;
          eoc = 1'b0;
        end
      join_none
    end
  end

  always @(negedge rd_n) begin
    if (!rst) begin
      rd_falls++;
      rd_fall_t = $realtime;
      // R6 chip select and address ahead of read
      chk(cs_n == 1'b0, "R6", "cs low at read fall", cs_n, 0);
      chk(($realtime - addr_t) >= 9.9, "R6", "addr setup ns", longint'($realtime - addr_t), 10);
    end
  end

  always @(posedge rd_n) begin
    if (started) begin
      rd_rise_t = $realtime;
      // R6 read width
      chk(($realtime - rd_fall_t) >= 29.9, "R6", "read low ns", longint'($realtime - rd_fall_t), 30);
      chk(cs_n == 1'b1, "R6", "cs rises with read", cs_n, 1);
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit         is_err;
    logic [2:0] ch;
    logic [7:0] d;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (!rst && (valid || err)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", {valid, err}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(err == e.is_err, "R9", "error flag", err, e.is_err);
        chk(valid == !e.is_err, "R8", "valid flag", valid, !e.is_err);
        if (!e.is_err) begin
          chk(sdata == e.d, "R8", "sample", sdata, e.d);
          chk(schan == e.ch, "R8", "channel tag", schan, e.ch);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_conv(input logic [2:0] ch, input bit ap, input logic [7:0] v,
                          input int exp_cyc, input bit nomute_off, input bit inject,
                          input string tag);
    exp_t e;
    int n;
    @(negedge clk);
    mute    = nomute_off;
    lvl     = v;
    e.is_err = nomute_off;
    e.ch    = ch;
    e.d     = v;
    q.push_back(e);
    chan    = ch;
    auto_pd = ap;
    req     = 1'b1;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (convst_n == 1'b1) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_cyc, tag, "request-to-convst cycles", n, exp_cyc);
    if (inject) begin
      // R2 request while busy must be ignored
      chan = 3'd6;
      req  = 1'b1;
      @(negedge clk);
      req  = 1'b0;
      chk(addr == ch, "R2", "address after busy request", addr, ch);
    end
    while (busy) @(negedge clk);
    mute = 1'b0;
  endtask

  initial begin
    int rf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(convst_n == 1'b1, "R1", "convst in reset", convst_n, 1);
    chk(cs_n == 1'b1 && rd_n == 1'b1, "R1", "cs/rd in reset", {cs_n, rd_n}, 3);
    chk(busy == 1'b0 && valid == 1'b0 && err == 1'b0, "R1", "busy/valid/err in reset",
        {busy, valid, err}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(convst_n == 1'b1 && busy == 1'b0, "R1", "idle after reset", {convst_n, busy}, 2);

    run_conv(3'd3, 1'b0, 8'h5A, 3125, 1'b0, 1'b0, "R10");
    run_conv(3'd5, 1'b0, 8'hA3, 25,   1'b0, 1'b0, "R4");
    chk(convst_n == 1'b1, "R4", "convst high after normal", convst_n, 1);
    run_conv(3'd1, 1'b0, 8'h00, 25,   1'b0, 1'b1, "R2");
    run_conv(3'd7, 1'b1, 8'hFF, 25,   1'b0, 1'b0, "R5");
    repeat (20) @(negedge clk);
    chk(convst_n == 1'b0, "R5", "convst held low in auto mode", convst_n, 0);
    run_conv(3'd0, 1'b1, 8'h11, 3125, 1'b0, 1'b0, "R5");
    run_conv(3'd2, 1'b0, 8'h7C, 3125, 1'b0, 1'b0, "R5");
    rf = rd_falls;
    run_conv(3'd4, 1'b0, 8'h99, 25,   1'b1, 1'b0, "R9");
    chk(rd_falls == rf, "R9", "no read after timeout", rd_falls, rf);
    run_conv(3'd6, 1'b0, 8'h42, 3125, 1'b0, 1'b0, "R9");
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R8", "results outstanding", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule